// File: doc/BRIEF.md
# Disable-Events Command Sequencer

After a rejected in-band interrupt, a controller tells the offending target (or every target) to stop raising that kind of event. This block turns one request into the ordered list of bus primitives that carries the disable-events common command, and hands those primitives one at a time to a lower-level bus engine over a valid/ready handshake. The bus engine owns pin timing and arbitration. This block only decides which primitive comes next and what it contains.

A request carries a mode bit (broadcast or direct), a 7-bit target address and an event byte. The broadcast form opens with the broadcast address, writes the broadcast command code and then the event byte. The direct form writes the direct command code after the broadcast address, then addresses the chosen target with a repeated start, and then writes the event byte. Both forms end with a stop. A single-cycle completion pulse follows.

Top module: `disec_seq`

## Requirements
- R1: After reset, `busy_o`, `prim_valid_o` and `done_o` are all low.
- R2: A `go_i` pulse while idle makes `busy_o` and `prim_valid_o` high in the next cycle. The first primitive is a start (kind code 0) to address 0x7E with `prim_rnw_o`=0 and `prim_i3c_o`=1.
- R3: In broadcast mode (`direct_i`=0), the second primitive is a byte write (kind code 1) with data 0x01.
- R4: In direct mode (`direct_i`=1), the second primitive is a byte write with data 0x81. The third is a repeated start (kind code 0) to the captured target address with `prim_rnw_o`=0.
- R5: The last byte write carries the captured event byte unchanged. Bit 3 (0x08) disables hot-join, bit 1 (0x02) disables controller-role requests, and bit 0 (0x01) disables target interrupts.
- R6: A stop (kind code 2) follows the event byte write. In total there are 4 primitives in broadcast mode and 5 in direct mode.
- R7: A primitive stays valid with unchanged fields until `prim_ready_i` is high. The next primitive is presented in the cycle after acceptance, with no gap.
- R8: `go_i` and the request inputs are ignored while `busy_o` is high. The sequence in progress keeps its captured values, and no second sequence follows it.
- R9: `done_o` is high for exactly one cycle, in the cycle after the stop is accepted. `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Request strobe |
| direct_i | input | 1 | 1 = direct form, 0 = broadcast form |
| tgt_addr_i | input | 7 | Target address for the direct form |
| events_i | input | 8 | Event mask byte |
| busy_o | output | 1 | Sequence in progress |
| prim_valid_o | output | 1 | Primitive request valid |
| prim_kind_o | output | 2 | 0 start, 1 byte write, 2 stop |
| prim_addr_o | output | 7 | Address for a start |
| prim_rnw_o | output | 1 | Direction for a start (always write) |
| prim_i3c_o | output | 1 | Use I3C signalling |
| prim_data_o | output | 8 | Byte for a write |
| prim_ready_i | input | 1 | Bus engine accepts the primitive |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case is a new request arriving in the middle of a sequence, while a primitive is stalled by the bus engine. The bench holds `prim_ready_i` low for several cycles on the command byte. During that stall it pulses `go_i` with a different mode, address and event byte. It then checks that the remaining primitives still carry the original values, and that no further primitive appears after the single done pulse. The vector table also varies the stall length per primitive. This exercises both zero-wait back-to-back acceptance and long holds.

// File: rtl/disec_pkg.sv
package disec_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PRIM_START = 2'd0,
    PRIM_WRITE = 2'd1,
    PRIM_STOP  = 2'd2
  } prim_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OPEN   = 3'd1,
    ST_CCC    = 3'd2,
    ST_RESTART = 3'd3,
    ST_MASK   = 3'd4,
    ST_CLOSE  = 3'd5
  } step_e;

  typedef struct packed {
    logic              direct;
    logic [ADDR_W-1:0] tgt;
    logic [BYTE_W-1:0] events;
  } req_t;

  // Successor of a step; the repeated start only exists in direct mode.
  function automatic step_e step_after(step_e cur, logic direct);
    case (cur)
      ST_OPEN:    return ST_CCC;
      ST_CCC:     return direct ? ST_RESTART : ST_MASK;
      ST_RESTART: return ST_MASK;
      ST_MASK:    return ST_CLOSE;
      default:    return ST_IDLE;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] ccc_code(logic direct,
                                                 logic [BYTE_W-1:0] bc_code,
                                                 logic [BYTE_W-1:0] dir_code);
    return direct ? dir_code : bc_code;
  endfunction

endpackage

// File: rtl/disec_req_capture.sv
module disec_req_capture
  import disec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  req_t req_in,
  output req_t req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else if (take) req_q <= req_in;
  end
endmodule

// File: rtl/disec_step_fsm.sv
module disec_step_fsm
  import disec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  advance,
  input  logic  direct,
  output step_e step_q,
  output logic  last_fire,
  output logic  done_q
);
  assign last_fire = advance && (step_q == ST_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= last_fire;
      if (step_q == ST_IDLE) begin
        if (start) step_q <= ST_OPEN;
      end else if (advance) begin
        step_q <= step_after(step_q, direct);
      end
    end
  end
endmodule

// File: rtl/disec_prim_map.sv
module disec_prim_map
  import disec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E,
  parameter logic [BYTE_W-1:0] CCC_BCAST  = 8'h01,
  parameter logic [BYTE_W-1:0] CCC_DIRECT = 8'h81
) (
  input  step_e             step,
  input  req_t              req,
  output logic              valid,
  output prim_kind_e        kind,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] data
);
  always_comb begin
    valid = 1'b1;
    kind  = PRIM_START;
    addr  = '0;
    data  = '0;
    case (step)
      ST_OPEN:    addr = BCAST_ADDR;
      ST_CCC: begin
        kind = PRIM_WRITE;
        data = ccc_code(req.direct, CCC_BCAST, CCC_DIRECT);
      end
      ST_RESTART: addr = req.tgt;
      ST_MASK: begin
        kind = PRIM_WRITE;
        data = req.events;
      end
      ST_CLOSE:   kind = PRIM_STOP;
      default:    valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/disec_seq.sv
module disec_seq
  import disec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E,
  parameter logic [BYTE_W-1:0] CCC_BCAST  = 8'h01,
  parameter logic [BYTE_W-1:0] CCC_DIRECT = 8'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              direct_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [BYTE_W-1:0] events_i,
  output logic              busy_o,
  output logic              prim_valid_o,
  output logic [1:0]        prim_kind_o,
  output logic [ADDR_W-1:0] prim_addr_o,
  output logic              prim_rnw_o,
  output logic              prim_i3c_o,
  output logic [BYTE_W-1:0] prim_data_o,
  input  logic              prim_ready_i,
  output logic              done_o
);
  step_e      step;
  req_t       req_q;
  req_t       req_in;
  prim_kind_e kind;
  logic       go_accept;
  logic       hs_fire;
  logic       last_fire;
  logic       map_valid;

  assign busy_o    = (step != ST_IDLE);
  assign go_accept = go_i && !busy_o;
  assign hs_fire   = prim_valid_o && prim_ready_i;
  assign req_in    = '{direct: direct_i, tgt: tgt_addr_i, events: events_i};

  disec_req_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(go_accept), .req_in(req_in), .req_q(req_q)
  );

  disec_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(go_accept), .advance(hs_fire),
    .direct(req_q.direct), .step_q(step), .last_fire(last_fire), .done_q(done_o)
  );

  disec_prim_map #(
    .BCAST_ADDR(BCAST_ADDR), .CCC_BCAST(CCC_BCAST), .CCC_DIRECT(CCC_DIRECT)
  ) u_map (
    .step(step), .req(req_q), .valid(map_valid), .kind(kind),
    .addr(prim_addr_o), .data(prim_data_o)
  );

  assign prim_valid_o = map_valid;
  assign prim_kind_o  = kind;
  assign prim_rnw_o   = 1'b0;
  assign prim_i3c_o   = map_valid;
endmodule

// File: rtl/disec_seq_chk.sv
module disec_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_accept,
  input logic       hs_fire,
  input logic       last_fire,
  input logic       busy_o,
  input logic       prim_valid_o,
  input logic [1:0] prim_kind_o,
  input logic [6:0] prim_addr_o,
  input logic [7:0] prim_data_o,
  input logic       done_o
);
  // R2
  first_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> (prim_valid_o && prim_kind_o == 2'd0 && prim_addr_o == 7'h7E));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_valid_o && !hs_fire) |=> (prim_valid_o && $stable(prim_kind_o)
      && $stable(prim_addr_o) && $stable(prim_data_o)));

  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fire && !last_fire) |=> prim_valid_o);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hs_fire) |=> busy_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (done_o && !busy_o));

  // R6
  stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fire && prim_kind_o == 2'd2) |=> !prim_valid_o);
endmodule

bind disec_seq disec_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_accept(go_accept), .hs_fire(hs_fire),
  .last_fire(last_fire), .busy_o(busy_o), .prim_valid_o(prim_valid_o),
  .prim_kind_o(prim_kind_o), .prim_addr_o(prim_addr_o),
  .prim_data_o(prim_data_o), .done_o(done_o)
);

// File: tb/disec_seq_tb.sv
module disec_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go_i = 1'b0, direct_i = 1'b0, prim_ready_i = 1'b0;
  logic [6:0] tgt_addr_i = '0;
  logic [7:0] events_i = '0;
  logic busy_o, prim_valid_o, prim_rnw_o, prim_i3c_o, done_o;
  logic [1:0] prim_kind_o;
  logic [6:0] prim_addr_o;
  logic [7:0] prim_data_o;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  disec_seq u_dut (.*);

  // {direct, tgt[6:0], events[7:0], stall[3:0]}
  localparam logic [19:0] VECS [0:5] = '{
    {1'b0, 7'h00, 8'h08, 4'd0},
    {1'b1, 7'h12, 8'h02, 4'd0},
    {1'b1, 7'h3A, 8'h01, 4'd3},
    {1'b0, 7'h55, 8'h0B, 4'd2},
    {1'b1, 7'h7F, 8'hFF, 4'd1},
    {1'b1, 7'h01, 8'h00, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit dir, input logic [6:0] tgt, input logic [7:0] ev,
                         input int stall, input bit inject);
    int n;
    logic [1:0] ek [0:4];
    logic [6:0] ea [0:4];
    logic [7:0] ed [0:4];
    ek[0] = 2'd0; ea[0] = 7'h7E; ed[0] = 8'h00;
    ek[1] = 2'd1; ea[1] = 7'h00; ed[1] = dir ? 8'h81 : 8'h01;
    if (dir) begin
      ek[2] = 2'd0; ea[2] = tgt; ed[2] = 8'h00;
      n = 5;
    end else n = 4;
    ek[n-2] = 2'd1; ea[n-2] = 7'h00; ed[n-2] = ev;
    ek[n-1] = 2'd2; ea[n-1] = 7'h00; ed[n-1] = 8'h00;
    @(negedge clk);
    go_i = 1'b1; direct_i = dir; tgt_addr_i = tgt; events_i = ev;
    @(negedge clk);
    go_i = 1'b0; direct_i = ~dir; tgt_addr_i = ~tgt; events_i = ~ev;
    chk(busy_o && prim_valid_o, "R2 busy/valid after go", {busy_o, prim_valid_o}, 3);
    for (int i = 0; i < n; i++) begin
      chk(prim_valid_o, "R7 valid with no gap", prim_valid_o, 1);
      for (int s = 0; s < stall; s++) begin
        if (inject && i == 1 && s == 0) begin
          go_i = 1'b1; direct_i = ~dir; tgt_addr_i = 7'h2C; events_i = 8'hA5;
        end
        @(negedge clk);
        go_i = 1'b0;
        chk(prim_valid_o && prim_kind_o == ek[i] && prim_data_o == ed[i],
            "R7 held while stalled", prim_data_o, ed[i]);
      end
      chk(prim_kind_o == ek[i], (i == n-1) ? "R6 kind" : "R2/R4 kind", prim_kind_o, ek[i]);
      chk(prim_addr_o == ea[i] && prim_rnw_o == 1'b0 && prim_i3c_o == 1'b1,
          (i == 2 && dir) ? "R4 target addr" : "R2 addr/rnw/i3c", prim_addr_o, ea[i]);
      chk(prim_data_o == ed[i], (i == 1) ? (dir ? "R4 ccc" : "R3 ccc") :
          (i == n-2) ? "R5 event byte" : "R8 data", prim_data_o, ed[i]);
      prim_ready_i = 1'b1;
      @(negedge clk);
      prim_ready_i = 1'b0;
    end
    chk(done_o && !busy_o && !prim_valid_o, "R9 done after stop",
        {done_o, busy_o, prim_valid_o}, 4);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk(!prim_valid_o && !busy_o, "R8 no second sequence", {prim_valid_o, busy_o}, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy_o && !prim_valid_o && !done_o, "R1 reset state",
        {busy_o, prim_valid_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !prim_valid_o && !done_o, "R1 idle after reset",
        {busy_o, prim_valid_o, done_o}, 0);
    for (int v = 0; v < 6; v++)
      run_seq(VECS[v][19], VECS[v][18:12], VECS[v][11:4], int'(VECS[v][3:0]), 1'b0);
    // R8: request during a stalled broadcast sequence, then during a direct one
    run_seq(1'b0, 7'h11, 8'h08, 4, 1'b1);
    run_seq(1'b1, 7'h44, 8'h02, 3, 1'b1);
    // R5: each single event bit
    run_seq(1'b1, 7'h09, 8'h01, 0, 1'b0);
    run_seq(1'b0, 7'h09, 8'h02, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule